// File: doc/BRIEF.md
# I2C SCL Clock Divider Generator

This block derives the serial clock of an I2C controller from a fast system clock. It works in two stages. A prescaler divides the system clock down to a module clock. The module clock appears as a one-cycle enable pulse, so the whole block stays on the single system clock domain. A phase timer then counts module-clock ticks to time the low half and the high half of each SCL period.

Each half lasts its programmed count plus a fixed overhead. The overhead depends on the prescaler setting: 7 ticks when the prescaler is 0, 6 ticks when it is 1, and 5 ticks when it is 2 or more. A programmed high count of zero stops the clock from being generated at all.

The three 16-bit divider words are captured only while the block is held in reset by its release bit. Once the release bit is set, those captured values stay fixed. The controller raises a run request to start clocking. SCL then falls on the next module tick. When the request is withdrawn, clocking stops at the end of a high phase, and SCL stays high.

Two strobes serve a byte shifter:
- The change strobe marks the middle of every low phase, the point where data may change.
- The sample strobe marks every SCL rising edge, the point where data is sampled.

Top module: `scl_divgen`

## Requirements
- R1: While `rel_en` is 0, `mclk_en`, `chg_stb` and `smp_stb` stay 0 and `scl_o` stays 1, whatever `run_req` does.
- R2: With `rel_en` at 1, `mclk_en` is a one-cycle pulse that repeats every PSC+1 system clocks, where PSC is the captured `psc_in`.
- R3: A low phase lasts CLKL+d module ticks. d is 7 for PSC=0, 6 for PSC=1 and 5 for PSC>=2.
- R4: A high phase lasts CLKH+d module ticks, with d chosen as in R3.
- R5: A captured high count of 0 keeps `scl_o` at 1 and both strobes at 0 even with `run_req` at 1. The prescaler keeps pulsing.
- R6: With `run_req` at 0, `scl_o` idles at 1. Once `run_req` is 1, `scl_o` falls within PSC+2 system clocks, so every run starts with a low phase.
- R7: When `run_req` drops, the current phases finish at full length. `scl_o` then stays at 1 and does not fall again.
- R8: Divider inputs are captured while `rel_en` is 0. Changes to them while `rel_en` is 1 have no effect on the clock.
- R9: `chg_stb` pulses for one cycle in every low phase, after floor((CLKL+d)/2) module ticks of that phase. It is never high while `scl_o` is 1.
- R10: `smp_stb` is 1 exactly in the cycles where `scl_o` has just risen from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rel_en | input | 1 | Module reset release: 0 holds the block in reset and captures the divider words |
| run_req | input | 1 | Clocking request from the controller |
| psc_in | input | 16 | Prescaler value (divide by value+1) |
| low_in | input | 16 | Low-phase count before overhead |
| high_in | input | 16 | High-phase count before overhead; 0 disables SCL |
| mclk_en | output | 1 | One-cycle module-clock enable |
| scl_o | output | 1 | SCL drive level |
| chg_stb | output | 1 | Mid-low-phase data change strobe |
| smp_stb | output | 1 | SCL rising-edge data sample strobe |

## Verification
The first `mclk_en` pulse appears PSC+1 system clocks after `rel_en` is sampled high. Each SCL level change and each strobe shows up in the cycle after the clock edge that consumes a module tick.

The bench samples every output on the falling clock edge. It counts the `mclk_en` pulses seen while `scl_o` is low and while it is high, so each phase length is measured in ticks rather than in absolute cycle numbers. This makes the phase checks independent of the prescaler phase at the moment `run_req` rises.

`smp_stb` is compared against a rise seen in the same sampled cycle. `chg_stb` is tied to the tick count reached before that cycle's own pulse is added. The start latency is bounded by PSC+2 cycles.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } phase_e;

   // per-phase overhead in module ticks, chosen by the prescaler setting
   function automatic logic [3:0] ovh_of(input logic [31:0] psc);
      if (psc == 32'd0)      return 4'd7;
      else if (psc == 32'd1) return 4'd6;
      else                   return 4'd5;
   endfunction

endpackage

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold
   import scl_div_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int FIXED_OVH = 0,
   localparam int PH_W     = CNT_W + 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rel_en,
   input  logic [CNT_W-1:0] psc_in,
   input  logic [CNT_W-1:0] low_in,
   input  logic [CNT_W-1:0] high_in,
   output logic [CNT_W-1:0] psc_q,
   output logic [PH_W-1:0]  low_len,
   output logic [PH_W-1:0]  high_len,
   output logic             hi_zero
);

   logic [3:0] ovh;

   generate
      if (FIXED_OVH == 0) begin : g_ovh_psc
         assign ovh = ovh_of(32'(psc_in));
      end else begin : g_ovh_fixed
         assign ovh = 4'(FIXED_OVH);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_q    <= '0;
         low_len  <= '0;
         high_len <= '0;
         hi_zero  <= 1'b1;
      end else if (!rel_en) begin
         psc_q    <= psc_in;
         low_len  <= PH_W'(low_in) + PH_W'(ovh);
         high_len <= PH_W'(high_in) + PH_W'(ovh);
         hi_zero  <= (high_in == '0);
      end
   end

   // R8
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_en && $past(rel_en)) |->
         ($stable(low_len) && $stable(high_len) && $stable(psc_q) && $stable(hi_zero)));

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
   parameter int CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rel_en,
   input  logic [CNT_W-1:0] psc_q,
   output logic             tick
);

   logic [CNT_W-1:0] pc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc   <= '0;
         tick <= 1'b0;
      end else if (!rel_en) begin
         pc   <= '0;
         tick <= 1'b0;
      end else if (pc == psc_q) begin
         pc   <= '0;
         tick <= 1'b1;
      end else begin
         pc   <= pc + CNT_W'(1);
         tick <= 1'b0;
      end
   end

   // R1
   tick_off_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rel_en |=> !tick);

   // R2
   tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && psc_q != '0 && rel_en) |=> !tick);

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
   import scl_div_pkg::*;
#(
   parameter int CNT_W = 16,
   localparam int PH_W = CNT_W + 1
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rel_en,
   input  logic            run_req,
   input  logic            tick,
   input  logic [PH_W-1:0] low_len,
   input  logic [PH_W-1:0] high_len,
   input  logic            hi_zero,
   output logic            scl,
   output logic            chg_stb,
   output logic            smp_stb
);

   phase_e          st;
   logic [PH_W-1:0] cnt;
   logic [PH_W-1:0] half;
   logic            go_on;

   assign half  = low_len >> 1;
   assign go_on = run_req && !hi_zero;
   assign scl   = (st != PH_LOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= PH_IDLE;
         cnt     <= '0;
         chg_stb <= 1'b0;
         smp_stb <= 1'b0;
      end else if (!rel_en) begin
         st      <= PH_IDLE;
         cnt     <= '0;
         chg_stb <= 1'b0;
         smp_stb <= 1'b0;
      end else begin
         chg_stb <= 1'b0;
         smp_stb <= 1'b0;
         if (tick) begin
            case (st)
               PH_IDLE: begin
                  if (go_on) begin
                     st  <= PH_LOW;
                     cnt <= '0;
                  end
               end
               PH_LOW: begin
                  if (cnt == half - PH_W'(1)) chg_stb <= 1'b1;
                  if (cnt == low_len - PH_W'(1)) begin
                     st      <= PH_HIGH;
                     cnt     <= '0;
                     smp_stb <= 1'b1;
                  end else begin
                     cnt <= cnt + PH_W'(1);
                  end
               end
               PH_HIGH: begin
                  if (cnt == high_len - PH_W'(1)) begin
                     st  <= go_on ? PH_LOW : PH_IDLE;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt + PH_W'(1);
                  end
               end
               default: begin
                  st  <= PH_IDLE;
                  cnt <= '0;
               end
            endcase
         end
      end
   end

   // R3
   low_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_LOW) |-> (cnt < low_len));

   // R4
   high_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_HIGH) |-> (cnt < high_len));

   // R5
   zero_high_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_zero |-> (scl && !chg_stb && !smp_stb));

   // R6
   fall_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl) |-> $past(run_req));

   // R9
   chg_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chg_stb |-> !scl);

   // R10
   smp_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |-> (scl && !$past(scl)));

endmodule

// File: rtl/scl_divgen.sv
module scl_divgen #(
   parameter int CNT_W     = 16,
   parameter int FIXED_OVH = 0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rel_en,
   input  logic             run_req,
   input  logic [CNT_W-1:0] psc_in,
   input  logic [CNT_W-1:0] low_in,
   input  logic [CNT_W-1:0] high_in,
   output logic             mclk_en,
   output logic             scl_o,
   output logic             chg_stb,
   output logic             smp_stb
);

   localparam int PH_W = CNT_W + 1;

   generate
      if (CNT_W < 4 || CNT_W > 31) begin : g_bad_width
         $error("scl_divgen: CNT_W must lie in 4..31");
      end
      if (FIXED_OVH != 0 && (FIXED_OVH < 2 || FIXED_OVH > 15)) begin : g_bad_ovh
         $error("scl_divgen: FIXED_OVH must be 0 or lie in 2..15");
      end
   endgenerate

   logic [CNT_W-1:0] psc_q;
   logic [PH_W-1:0]  low_len;
   logic [PH_W-1:0]  high_len;
   logic             hi_zero;
   logic             tick;

   scl_cfg_hold #(.CNT_W(CNT_W), .FIXED_OVH(FIXED_OVH)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .rel_en   (rel_en),
      .psc_in   (psc_in),
      .low_in   (low_in),
      .high_in  (high_in),
      .psc_q    (psc_q),
      .low_len  (low_len),
      .high_len (high_len),
      .hi_zero  (hi_zero)
   );

   scl_prescaler #(.CNT_W(CNT_W)) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .rel_en (rel_en),
      .psc_q  (psc_q),
      .tick   (tick)
   );

   scl_phase_timer #(.CNT_W(CNT_W)) u_ph (
      .clk      (clk),
      .rst_n    (rst_n),
      .rel_en   (rel_en),
      .run_req  (run_req),
      .tick     (tick),
      .low_len  (low_len),
      .high_len (high_len),
      .hi_zero  (hi_zero),
      .scl      (scl_o),
      .chg_stb  (chg_stb),
      .smp_stb  (smp_stb)
   );

   assign mclk_en = tick;

   // R1
   held_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rel_en && !$past(rel_en)) |-> (scl_o && !mclk_en && !chg_stb && !smp_stb));

endmodule

// File: tb/scl_divgen_test.sv
module scl_divgen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rel_en = 1'b0;
   logic        run_req = 1'b0;
   logic [15:0] psc_in = '0;
   logic [15:0] low_in = '0;
   logic [15:0] high_in = '0;
   logic        mclk_en, scl_o, chg_stb, smp_stb;

   int checks = 0;
   int failures = 0;

   // monitor state
   int cyc_n = 0, last_en = 0, last_gap = 0, min_gap = 1000000;
   int falls = 0, rises = 0, lo_en = 0, hi_en = 0, last_lo = 0, last_hi = 0;
   int chg_at = 0, chg_cnt = 0, en_cnt = 0, smp_bad = 0, chg_bad = 0;
   bit prev_scl = 1'b1, in_hi = 1'b0, fell, rose;

   always #10 clk = ~clk;

   scl_divgen uut (
      .clk(clk), .rst_n(rst_n), .rel_en(rel_en), .run_req(run_req),
      .psc_in(psc_in), .low_in(low_in), .high_in(high_in),
      .mclk_en(mclk_en), .scl_o(scl_o), .chg_stb(chg_stb), .smp_stb(smp_stb)
   );

   always @(negedge clk) begin
      cyc_n++;
      if (rst_n) begin
         fell = prev_scl && !scl_o;
         rose = !prev_scl && scl_o;
         if (smp_stb != rose) smp_bad++;
         if (chg_stb && scl_o) chg_bad++;
         if (fell) begin
            falls++;
            if (in_hi) last_hi = hi_en;
            lo_en = 0;
         end
         if (rose) begin
            rises++;
            last_lo = lo_en;
            hi_en = 0;
            in_hi = 1'b1;
         end
         if (chg_stb) begin
            chg_at = lo_en;
            chg_cnt++;
         end
         if (mclk_en) begin
            en_cnt++;
            last_gap = cyc_n - last_en;
            if (last_gap < min_gap) min_gap = last_gap;
            last_en = cyc_n;
            if (!scl_o) lo_en++;
            else hi_en++;
         end
         prev_scl = scl_o;
      end
   end

   function automatic int exp_d(input int p);
      if (p == 0) return 7;
      if (p == 1) return 6;
      return 5;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
      #1;
   endtask

   task automatic clr();
      falls = 0; rises = 0; lo_en = 0; hi_en = 0; last_lo = 0; last_hi = 0;
      chg_at = 0; chg_cnt = 0; en_cnt = 0; smp_bad = 0; chg_bad = 0;
      min_gap = 1000000; in_hi = 1'b0;
   endtask

   task automatic load(input int p, input int lo, input int hi);
      rel_en = 1'b0;
      run_req = 1'b0;
      psc_in = 16'(p);
      low_in = 16'(lo);
      high_in = 16'(hi);
      step(2);
      rel_en = 1'b1;
      step(2);
      clr();
   endtask

   task automatic wait_falls(input int n, input int lim);
      for (int i = 0; i < lim && falls < n; i++) step(1);
   endtask

   task automatic run_case(input int p, input int lo, input int hi);
      int el, eh, per, f0;
      el = lo + exp_d(p);
      eh = hi + exp_d(p);
      per = (el + eh) * (p + 1);
      load(p, lo, hi);
      step(3 * (p + 1) + 2);
      // R6 idle high without run
      chk(scl_o == 1'b1 && falls == 0, "R6 idle level", int'(scl_o), 1);
      run_req = 1'b1;
      step(p + 2);
      // R6 start with low phase promptly
      chk(falls == 1, "R6 start latency", falls, 1);
      wait_falls(4, 5 * per + 20);
      chk(last_lo == el, "R3 low ticks", last_lo, el);
      chk(last_hi == eh, "R4 high ticks", last_hi, eh);
      chk(last_gap == p + 1 && min_gap == p + 1, "R2 tick spacing", min_gap, p + 1);
      chk(chg_at == el / 2, "R9 change point", chg_at, el / 2);
      chk(chg_cnt == rises || chg_cnt == rises + 1, "R9 one per low", chg_cnt, rises);
      chk(smp_bad == 0, "R10 sample strobe", smp_bad, 0);
      chk(chg_bad == 0, "R9 change in low", chg_bad, 0);
      step($urandom_range(per, 0));
      run_req = 1'b0;
      f0 = falls;
      step(3 * per + 10);
      chk(scl_o == 1'b1 && falls == f0, "R7 stop after high", falls, f0);
      chk(last_lo == el, "R7 final low full", last_lo, el);
   endtask

   initial begin : watchdog
      wait (cyc_n >= 150000);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_n, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      int p, lo, hi;
      void'($urandom(32'd1234));
      step(3);
      rst_n = 1'b1;
      step(1);
      clr();
      // R1 reset / held state
      chk(scl_o == 1'b1, "R1 scl held", int'(scl_o), 1);
      chk(mclk_en == 1'b0 && chg_stb == 1'b0 && smp_stb == 1'b0,
          "R1 outputs held", int'(mclk_en), 0);
      run_req = 1'b1;
      step(30);
      chk(en_cnt == 0 && falls == 0 && scl_o == 1'b1, "R1 run ignored in reset", en_cnt + falls, 0);
      run_req = 1'b0;

      // directed: each overhead branch
      run_case(0, 4, 3);
      run_case(1, 5, 2);
      run_case(2, 3, 3);
      run_case(4, 0, 1);

      // R5 zero high count
      load(1, 4, 0);
      run_req = 1'b1;
      step(200);
      chk(falls == 0 && scl_o == 1'b1, "R5 no clock", falls, 0);
      chk(chg_cnt == 0 && smp_bad == 0, "R5 no strobes", chg_cnt, 0);
      chk(en_cnt > 0, "R5 prescaler runs", en_cnt, 1);
      run_req = 1'b0;

      // R8 changes while released are ignored
      load(0, 6, 4);
      run_req = 1'b1;
      step(5);
      psc_in = 16'd3;
      low_in = 16'd1;
      high_in = 16'd0;
      wait_falls(5, 400);
      chk(last_lo == 13, "R8 low unchanged", last_lo, 13);
      chk(last_hi == 11, "R8 high unchanged", last_hi, 11);
      chk(min_gap == 1, "R8 prescale unchanged", min_gap, 1);
      run_req = 1'b0;
      step(100);

      // random configurations
      for (int k = 0; k < 8; k++) begin
         p = $urandom_range(5, 0);
         lo = $urandom_range(8, 0);
         hi = $urandom_range(6, 1);
         run_case(p, lo, hi);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule